// File: doc/BRIEF.md
# Two-Operand NaN Propagation Unit

This block chooses the result of a two-input floating-point operation when at least one input is a NaN. It sorts each operand into non-NaN, quiet NaN or signaling NaN, and picks the operand to return using one of three run-time propagation policies. If the chosen operand is signaling, the block quiets it. It also raises the invalid flag. A default-NaN mode replaces the chosen value with the canonical quiet NaN.

The word width is a parameter, either 32 or 64 bits. The quiet bit is the most significant fraction bit and is set for a quiet NaN. Inputs are sampled on every rising clock edge and both outputs are registered, so an arithmetic pipeline can use the unit as one stage. The arithmetic of the surrounding operation is handled elsewhere.

Top module: `nanprop_unit`

## Requirements
- R1: An operand is a NaN when its exponent field is all ones and its fraction is non-zero. It is quiet when the fraction MSB is 1 and signaling when that bit is 0. An infinity, with an all-ones exponent and a zero fraction, is not a NaN.
- R2: `inv_flag` is 1 exactly when at least one operand is a signaling NaN. This holds for every policy and in both settings of `dflt_mode`.
- R3: With `dflt_mode`=1 the result is the canonical NaN: sign 0, exponent all ones, only the fraction MSB set (0x7FC00000 for 32 bits, 0x7FF8000000000000 for 64 bits). `inv_flag` still follows R2.
- R4: Policy code 2'b00 returns the first match in this order: a if signaling, b if signaling, a if quiet, otherwise b. Code 2'b11 behaves the same as 2'b00.
- R5: Policy code 2'b01 returns a when a is any kind of NaN, and b otherwise.
- R6: Under policy code 2'b10:
  - a signaling NaN paired with a quiet NaN yields the quiet one;
  - two NaNs of the same kind yield the one with the larger magnitude (see R7);
  - a NaN paired with a non-NaN yields the NaN.
- R7: For R6, magnitude is compared on each word shifted left by one bit, which drops the sign. On equal magnitudes, the operand whose raw word is numerically smaller counts as larger, so the positive one wins.
- R8: When the chosen operand is a signaling NaN, the result is that word with its fraction MSB set. The sign and the remaining payload bits are kept.
- R9: When the chosen operand is a quiet NaN, it passes through bit for bit.
- R10: When neither operand is a NaN and `dflt_mode`=0, the result equals b and `inv_flag` is 0.
- R11: `res` and `inv_flag` reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, both are held at zero.
- R12: Parameter `W` accepts only 32 and 64. Any other value stops elaboration. The exponent field is 8 bits for W=32 and 11 bits for W=64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | W | First operand word |
| op_b | input | W | Second operand word |
| policy | input | 2 | Propagation policy code (R4 to R6) |
| dflt_mode | input | 1 | Force canonical NaN result |
| res | output | W | Registered propagated result |
| inv_flag | output | 1 | Registered invalid-operation flag |

## Verification
Every result is due exactly one rising edge after its inputs are applied, because the selection logic feeds a single output register. The bench drives each stimulus on a falling edge and reads `res` and `inv_flag` on the next falling edge, half a period after the capturing edge. The checker's clocked properties compare the outputs with the inputs from one edge earlier. They are gated until one full cycle after reset has been released, so values held during reset never count as stimulus.

// File: rtl/nanprop_pkg.sv
package nanprop_pkg;

   // Operand classification
   typedef enum logic [1:0] {
      KIND_NUM    = 2'd0,
      KIND_QUIET  = 2'd1,
      KIND_SIGNAL = 2'd2
   } opnd_kind_e;

   // Propagation policy codes
   localparam logic [1:0] POL_ORDERED   = 2'b00;
   localparam logic [1:0] POL_FIRST_ANY = 2'b01;
   localparam logic [1:0] POL_MAGNITUDE = 2'b10;
   localparam logic [1:0] POL_ALIAS     = 2'b11;

   function automatic int exp_width(input int w);
      return (w == 64) ? 11 : 8;
   endfunction

endpackage

// File: rtl/nanprop_classify.sv
module nanprop_classify
   import nanprop_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] word,
   output opnd_kind_e   kind
);
   localparam int EXP_W  = exp_width(W);
   localparam int FRAC_W = W - 1 - EXP_W;

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_ones;
   logic              frac_nz;

   assign exp_f    = word[W-2 -: EXP_W];
   assign frac_f   = word[FRAC_W-1:0];
   assign exp_ones = &exp_f;
   assign frac_nz  = |frac_f;

   always_comb begin
      if (!(exp_ones && frac_nz))
         kind = KIND_NUM;
      else if (frac_f[FRAC_W-1])
         kind = KIND_QUIET;
      else
         kind = KIND_SIGNAL;
   end
endmodule

// File: rtl/nanprop_select.sv
module nanprop_select
   import nanprop_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] word_a,
   input  logic [W-1:0] word_b,
   input  opnd_kind_e   kind_a,
   input  opnd_kind_e   kind_b,
   input  logic [1:0]   policy,
   output logic         pick_b
);
   logic [W-1:0] mag_a;
   logic [W-1:0] mag_b;
   logic         a_bigger;
   logic         pick_ord;
   logic         pick_any;
   logic         pick_mag;

   // Magnitude order with the sign shifted out, positive wins a tie
   assign mag_a = {word_a[W-2:0], 1'b0};
   assign mag_b = {word_b[W-2:0], 1'b0};

   always_comb begin
      if (mag_a > mag_b)
         a_bigger = 1'b1;
      else if (mag_b > mag_a)
         a_bigger = 1'b0;
      else
         a_bigger = (word_a < word_b);
   end

   // Ordered: signaling a, signaling b, quiet a, else b
   always_comb begin
      if (kind_a == KIND_SIGNAL)
         pick_ord = 1'b0;
      else if (kind_b == KIND_SIGNAL)
         pick_ord = 1'b1;
      else if (kind_a == KIND_QUIET)
         pick_ord = 1'b0;
      else
         pick_ord = 1'b1;
   end

   assign pick_any = (kind_a == KIND_NUM);

   // Magnitude policy: quiet beats signaling, equal kinds use magnitude
   always_comb begin
      unique case (kind_a)
         KIND_SIGNAL: begin
            if (kind_b == KIND_SIGNAL)
               pick_mag = !a_bigger;
            else
               pick_mag = (kind_b == KIND_QUIET);
         end
         KIND_QUIET: begin
            if (kind_b == KIND_QUIET)
               pick_mag = !a_bigger;
            else
               pick_mag = 1'b0;
         end
         default: pick_mag = 1'b1;
      endcase
   end

   always_comb begin
      unique case (policy)
         POL_FIRST_ANY: pick_b = pick_any;
         POL_MAGNITUDE: pick_b = pick_mag;
         default:       pick_b = pick_ord;
      endcase
   end
endmodule

// File: rtl/nanprop_quiet.sv
module nanprop_quiet
   import nanprop_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] chosen,
   input  opnd_kind_e   chosen_kind,
   input  logic         dflt_mode,
   input  logic [W-1:0] dflt_word,
   output logic [W-1:0] result
);
   localparam int EXP_W  = exp_width(W);
   localparam int FRAC_W = W - 1 - EXP_W;
   localparam logic [W-1:0] QBIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};

   always_comb begin
      if (dflt_mode)
         result = dflt_word;
      else if (chosen_kind == KIND_SIGNAL)
         result = chosen | QBIT;
      else
         result = chosen;
   end
endmodule

// File: rtl/nanprop_unit.sv
module nanprop_unit
   import nanprop_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] op_a,
   input  logic [W-1:0] op_b,
   input  logic [1:0]   policy,
   input  logic         dflt_mode,
   output logic [W-1:0] res,
   output logic         inv_flag
);
   localparam int EXP_W  = exp_width(W);
   localparam int FRAC_W = W - 1 - EXP_W;

   logic [W-1:0] dflt_word;

   // Format variant: canonical NaN per width, reject other widths
   generate
      if (W == 32) begin : g_single
         assign dflt_word = 32'h7FC0_0000;
      end else if (W == 64) begin : g_double
         assign dflt_word = 64'h7FF8_0000_0000_0000;
      end else begin : g_bad
         $error("nanprop_unit: W must be 32 or 64");
         assign dflt_word = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
      end
   endgenerate

   logic [W-1:0] opnd [2];
   opnd_kind_e   kind [2];

   assign opnd[0] = op_a;
   assign opnd[1] = op_b;

   generate
      for (genvar i = 0; i < 2; i++) begin : g_cls
         nanprop_classify #(.W(W)) u_cls (
            .word (opnd[i]),
            .kind (kind[i])
         );
      end
   endgenerate

   logic         pick_b;
   logic [W-1:0] chosen;
   opnd_kind_e   chosen_kind;
   logic [W-1:0] res_d;
   logic         inv_d;

   nanprop_select #(.W(W)) u_sel (
      .word_a (opnd[0]),
      .word_b (opnd[1]),
      .kind_a (kind[0]),
      .kind_b (kind[1]),
      .policy (policy),
      .pick_b (pick_b)
   );

   assign chosen      = pick_b ? opnd[1] : opnd[0];
   assign chosen_kind = pick_b ? kind[1] : kind[0];

   nanprop_quiet #(.W(W)) u_qt (
      .chosen      (chosen),
      .chosen_kind (chosen_kind),
      .dflt_mode   (dflt_mode),
      .dflt_word   (dflt_word),
      .result      (res_d)
   );

   assign inv_d = (kind[0] == KIND_SIGNAL) || (kind[1] == KIND_SIGNAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res      <= '0;
         inv_flag <= 1'b0;
      end else begin
         res      <= res_d;
         inv_flag <= inv_d;
      end
   end
endmodule

// File: rtl/nanprop_unit_chk.sv
module nanprop_unit_chk #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] op_a,
   input logic [W-1:0] op_b,
   input logic [1:0]   policy,
   input logic         dflt_mode,
   input logic [W-1:0] res,
   input logic         inv_flag
);
   localparam int EXP_W  = (W == 64) ? 11 : 8;
   localparam int FRAC_W = W - 1 - EXP_W;
   localparam logic [W-1:0] QBIT = {{(W-FRAC_W){1'b0}}, 1'b1, {(FRAC_W-1){1'b0}}};
   localparam logic [W-1:0] CANON = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   logic a_nan, b_nan;
   assign a_nan = (&op_a[W-2 -: EXP_W]) && (|op_a[FRAC_W-1:0]);
   assign b_nan = (&op_b[W-2 -: EXP_W]) && (|op_b[FRAC_W-1:0]);

   logic res_qnan;
   assign res_qnan = (&res[W-2 -: EXP_W]) && res[FRAC_W-1];

   // R3: default mode yields the canonical pattern
   a_r3_canonical: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(dflt_mode) |-> res == CANON);

   // R8: any NaN input yields a quiet NaN result
   a_r8_result_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(a_nan || b_nan) |-> res_qnan);

   // R2: a raised flag always comes with a quiet NaN result
   a_r2_inv_nan: assert property (@(posedge clk) disable iff (!rst_n)
      armed && inv_flag |-> res_qnan);

   // R10: no NaN inputs, result is b and no flag
   a_r10_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(!a_nan && !b_nan && !dflt_mode) |-> (res == $past(op_b)) && !inv_flag);

   // R5: first-any policy returns quieted a when a is a NaN
   a_r5_first_any: assert property (@(posedge clk) disable iff (!rst_n)
      armed && $past(policy == 2'b01 && a_nan && !dflt_mode) |-> res == ($past(op_a) | QBIT));

   // R11: reset holds outputs at zero
   a_r11_reset: assert property (@(posedge clk)
      !rst_n |-> (res == '0) && !inv_flag);
endmodule

bind nanprop_unit nanprop_unit_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .op_a      (op_a),
   .op_b      (op_b),
   .policy    (policy),
   .dflt_mode (dflt_mode),
   .res       (res),
   .inv_flag  (inv_flag)
);

// File: tb/nanprop_unit_bench.sv
`timescale 1ns/1ps
module nanprop_unit_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [31:0] op_a = '0, op_b = '0;
   logic [1:0]  policy = '0;
   logic        dflt_mode = 1'b0;
   logic [31:0] res;
   logic        inv_flag;

   logic [63:0] wa = '0, wb = '0;
   logic [1:0]  wpol = '0;
   logic        wdm = 1'b0;
   logic [63:0] wres;
   logic        winv;

   nanprop_unit #(.W(32)) u_nanprop_unit (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .policy(policy),
      .dflt_mode(dflt_mode), .res(res), .inv_flag(inv_flag));

   nanprop_unit #(.W(64)) u_nanprop_unit_w64 (
      .clk(clk), .rst_n(rst_n), .op_a(wa), .op_b(wb), .policy(wpol),
      .dflt_mode(wdm), .res(wres), .inv_flag(winv));

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [31:0] QA = 32'h7FC0_0001, QB = 32'hFFC0_0002;
   localparam logic [31:0] SA = 32'h7F80_0005, SB = 32'hFF80_0003;
   localparam logic [31:0] ONE = 32'h3F80_0000, TWO = 32'h4000_0000;
   localparam logic [31:0] INF = 32'h7F80_0000, CANON = 32'h7FC0_0000;

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   // Drive on a falling edge, read one rising edge later on the next falling edge
   task automatic apply(input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] p, input logic dm);
      @(negedge clk);
      op_a = a; op_b = b; policy = p; dflt_mode = dm;
      @(negedge clk);
   endtask

   task automatic expect32(input string req, input logic [31:0] r, input logic inv);
      chk({req, " res"}, {32'h0, res}, {32'h0, r});
      chk({req, " inv"}, {63'h0, inv_flag}, {63'h0, inv});
   endtask

   task automatic t_reset;
      chk("R11 reset res", {32'h0, res}, 64'h0);
      chk("R11 reset inv", {63'h0, inv_flag}, 64'h0);
   endtask

   task automatic t_policy0;
      apply(QA, SB, 2'b00, 1'b0); expect32("R4 qa,sb", 32'hFFC0_0003, 1'b1);
      apply(SA, SB, 2'b00, 1'b0); expect32("R4 sa,sb", 32'h7FC0_0005, 1'b1);
      apply(QA, QB, 2'b00, 1'b0); expect32("R4 qa,qb R9", QA, 1'b0);
      apply(ONE, QB, 2'b00, 1'b0); expect32("R4 num,qb", QB, 1'b0);
   endtask

   task automatic t_policy1;
      apply(QA, SB, 2'b01, 1'b0); expect32("R5 qa,sb R2", QA, 1'b1);
      apply(ONE, SB, 2'b01, 1'b0); expect32("R5 num,sb R8", 32'hFFC0_0003, 1'b1);
      apply(INF, QB, 2'b01, 1'b0); expect32("R5 R1 inf,qb", QB, 1'b0);
   endtask

   task automatic t_policy2;
      apply(SA, QB, 2'b10, 1'b0); expect32("R6 sa,qb", QB, 1'b1);
      apply(QA, SB, 2'b10, 1'b0); expect32("R6 qa,sb", QA, 1'b1);
      apply(SA, SB, 2'b10, 1'b0); expect32("R6 sa,sb larger", 32'h7FC0_0005, 1'b1);
      apply(QA, QB, 2'b10, 1'b0); expect32("R6 qa,qb larger", QB, 1'b0);
      apply(SA, ONE, 2'b10, 1'b0); expect32("R6 sa,num", 32'h7FC0_0005, 1'b1);
   endtask

   task automatic t_tiebreak;
      apply(32'hFFC0_0007, 32'h7FC0_0007, 2'b10, 1'b0); expect32("R7 tie neg,pos", 32'h7FC0_0007, 1'b0);
      apply(32'h7FC0_0007, 32'hFFC0_0007, 2'b10, 1'b0); expect32("R7 tie pos,neg", 32'h7FC0_0007, 1'b0);
   endtask

   task automatic t_alias;
      apply(QA, SB, 2'b11, 1'b0); expect32("R4 alias qa,sb", 32'hFFC0_0003, 1'b1);
   endtask

   task automatic t_default;
      apply(QA, SB, 2'b01, 1'b1); expect32("R3 dflt sb", CANON, 1'b1);
      apply(QA, QB, 2'b10, 1'b1); expect32("R3 dflt qq", CANON, 1'b0);
   endtask

   task automatic t_nonan;
      apply(ONE, TWO, 2'b10, 1'b0); expect32("R10 num,num", TWO, 1'b0);
      apply(INF, ONE, 2'b01, 1'b0); expect32("R10 R1 inf,num", ONE, 1'b0);
   endtask

   task automatic t_wide;
      @(negedge clk);
      wa = 64'h7FF0_0000_0000_0001; wb = 64'h3FF0_0000_0000_0000; wpol = 2'b00; wdm = 1'b0;
      @(negedge clk);
      chk("R12 w64 quiet res", wres, 64'h7FF8_0000_0000_0001);
      chk("R12 w64 inv", {63'h0, winv}, 64'h1);
      @(negedge clk);
      wdm = 1'b1;
      @(negedge clk);
      chk("R12 w64 R3 dflt", wres, 64'h7FF8_0000_0000_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_policy0;
      t_policy1;
      t_policy2;
      t_tiebreak;
      t_alias;
      t_default;
      t_nonan;
      t_wide;
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule